// File: doc/BRIEF.md
# Quad Prescaled Down-Counter Timer

This block holds a bank of independent down-counting timer channels (four by default) behind a single-cycle register bus. Each channel has its own control byte. The control byte sets the enable, the reload behaviour, the counting width and a clock prescaler. A channel decrements once per prescaled tick. When it arrives at zero it raises a status flag. What it does at the next tick after that depends on its mode: it restarts from a staged reload value, it wraps to the all-ones value of its width, or it stays at zero.

The staged reload value lets software change the period of a running channel without disturbing the current count. The new value takes effect at the next reload. Writing the main load register replaces the count at once and also updates the staged value. All channels share one status block, made of a mask, a raw flag per channel, a masked view and a write-one-to-clear port. That block drives a single combined interrupt line.

Bus reads are combinational from the addressed register. Writes take effect at the clock edge. Addresses are byte offsets on 32-bit words. Channel n owns a window at 0x10 + 0x10*n.

Top module: `tmr_quad`

## Requirements
- R1: After reset every register reads zero, every count reads zero and `irq_o` is low.
- R2: A write to a channel's load word (window offset 0x0) sets the count at that edge to the written value limited to the channel's width. The same write stores the full value in both the load word and the staged-reload word (window offset 0xC). Both words read back the written value.
- R3: While enable (control bit 7) is set, the count drops by one per prescaled tick. Prescale code (control bits 3:2) 00 gives a tick every clock, 01 every 16 clocks, and 10 or 11 every 256 clocks. The prescaler restarts on a load write and when the enable bit is turned on. While enable is clear, the count holds.
- R4: A write to the staged-reload word does not change the running count. The new value is the one used at the next reload.
- R5: In periodic mode (bit 6 set, bit 0 clear), a tick at count zero loads the count from the staged-reload word.
- R6: In free-running mode (bit 6 clear, bit 0 clear), a tick at count zero wraps the count to all ones of the selected width.
- R7: In one-shot mode (bit 0 set), a count at zero stays at zero until the next load write. This mode takes priority over bit 6.
- R8: With control bit 1 clear, the channel counts in 16 bits: loads are cut to 16 bits and wrapping gives 0xFFFF. With bit 1 set, it counts in 32 bits.
- R9: Raw status bit n (offset 0x04) sets on the tick that takes channel n's count from 1 to 0. Writing 1 to bit n of offset 0x0C clears it. A set in the same cycle wins over a clear.
- R10: Masked status (offset 0x08) equals raw status AND the mask word (offset 0x00). `irq_o` is high exactly when any masked bit is set.
- R11: The control word (window offset 0x8) reads back bits 7, 6, 3:2, 1 and 0, with every other bit zero. The clear word and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt, OR of masked status |

## Verification
The embedded properties check several rules on every cycle. A one-shot channel at zero stays there. A staged-reload write with no tick leaves the count alone. A periodic channel reloads the staged value at the zero tick. A zero event always leaves its raw flag set. A clear with no event leaves the flag clear. A slow prescaler never ticks on two cycles in a row. Only the bench scenarios can show the exact tick spacing for each prescale code, the wrap values at each width, the register readback and masking, and the interaction between a staged value written mid-count and the reload that follows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef struct packed {
      logic       en;
      logic       periodic;
      logic [1:0] ps;
      logic       wide;
      logic       oneshot;
   } ctl_t;

   localparam logic [1:0] SLOT_LOAD = 2'd0;
   localparam logic [1:0] SLOT_CNT  = 2'd1;
   localparam logic [1:0] SLOT_CTL  = 2'd2;
   localparam logic [1:0] SLOT_BG   = 2'd3;

   localparam logic [1:0] SH_MASK   = 2'd0;
   localparam logic [1:0] SH_RAW    = 2'd1;
   localparam logic [1:0] SH_MIS    = 2'd2;
   localparam logic [1:0] SH_CLR    = 2'd3;

   function automatic ctl_t byte_to_ctl(input logic [7:0] b);
      ctl_t c;
      c.en       = b[7];
      c.periodic = b[6];
      c.ps       = b[3:2];
      c.wide     = b[1];
      c.oneshot  = b[0];
      return c;
   endfunction

   function automatic logic [7:0] ctl_to_byte(input ctl_t c);
      return {c.en, c.periodic, 2'b00, c.ps, c.wide, c.oneshot};
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_MID = 16,
   parameter int DIV_MAX = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic [1:0] code,
   output logic       tick
);
   localparam int PW = $clog2(DIV_MAX);

   if (DIV_MID < 2 || DIV_MAX < DIV_MID) begin : g_bad_div
      $error("tmr_prescale: need 2 <= DIV_MID <= DIV_MAX");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;

   always_comb begin
      case (code)
         2'b00:   lim = '0;
         2'b01:   lim = PW'(DIV_MID - 1);
         default: lim = PW'(DIV_MAX - 1);
      endcase
   end

   assign tick = run && !restart && (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (run)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
   end

   // R3
   slow_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && code != 2'b00) |=> (!tick || code == 2'b00));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16,
   parameter int DIV_MID  = 16,
   parameter int DIV_MAX  = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic             ctl_we,
   input  logic             bg_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] load_o,
   output logic [CNT_W-1:0] bg_o,
   output logic [7:0]       ctl_o,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] FULL_MASK   = '1;
   localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   ctl_t             ctl_q;
   logic [CNT_W-1:0] cnt_q, load_q, bg_q;
   logic [CNT_W-1:0] wmask, cnt_m;
   logic             tick, restart;

   assign wmask   = ctl_q.wide ? FULL_MASK : NARROW_MASK;
   assign cnt_m   = cnt_q & wmask;
   assign restart = ld_we || (ctl_we && wdata[7] && !ctl_q.en);

   tmr_prescale #(.DIV_MID(DIV_MID), .DIV_MAX(DIV_MAX)) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .run    (ctl_q.en),
      .code   (ctl_q.ps),
      .tick   (tick)
   );

   assign zero_evt = tick && !ld_we && (cnt_m == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cnt_q  <= '0;
         load_q <= '0;
         bg_q   <= '0;
      end else begin
         if (ctl_we) ctl_q <= byte_to_ctl(wdata[7:0]);
         if (ld_we) begin
            load_q <= wdata;
            bg_q   <= wdata;
            cnt_q  <= wdata & wmask;
         end else begin
            if (bg_we) bg_q <= wdata;
            if (tick) begin
               if (cnt_m != '0)        cnt_q <= cnt_m - 1'b1;
               else if (ctl_q.oneshot) cnt_q <= '0;
               else if (ctl_q.periodic) cnt_q <= bg_q & wmask;
               else                    cnt_q <= wmask;
            end
         end
      end
   end

   assign count_o = cnt_m;
   assign load_o  = load_q;
   assign bg_o    = bg_q;
   assign ctl_o   = ctl_to_byte(ctl_q);

   // R7
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.oneshot && cnt_m == '0 && !ld_we && !ctl_we) |=> (count_o == '0));

   // R4
   bg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bg_we && !ld_we && !ctl_we && !tick) |=> $stable(count_o));

   // R5
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld_we && !ctl_we && !bg_we && cnt_m == '0 && ctl_q.periodic && !ctl_q.oneshot)
      |=> (count_o == (bg_o & wmask)));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mask_we,
   input  logic           clr_we,
   input  logic [NCH-1:0] wbits,
   input  logic [NCH-1:0] evt,
   output logic [NCH-1:0] mask_o,
   output logic [NCH-1:0] raw_o,
   output logic [NCH-1:0] mis_o,
   output logic           irq_o
);
   logic [NCH-1:0] mask_q, raw_q, clr_bits;

   assign clr_bits = clr_we ? wbits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         raw_q  <= '0;
      end else begin
         if (mask_we) mask_q <= wbits;
         raw_q <= (raw_q & ~clr_bits) | evt;
      end
   end

   assign mask_o = mask_q;
   assign raw_o  = raw_q;
   assign mis_o  = raw_q & mask_q;
   assign irq_o  = |mis_o;

   // R9
   evt_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((raw_o & $past(evt)) == $past(evt)));

   // R9
   clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((raw_o & $past(wbits & ~evt)) == '0));

   // R10
   irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_we && !clr_we && evt == '0) |=> (irq_o == $past(irq_o)));
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
   import tmr_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16,
   parameter int ADDR_W   = 8,
   parameter int DIV_MID  = 16,
   parameter int DIV_MAX  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_o
);
   localparam int WIN_W   = ADDR_W - 4;
   localparam int MAX_NCH = (1 << WIN_W) - 1;

   if (NCH < 1 || NCH > MAX_NCH || NCH > CNT_W) begin : g_bad_nch
      $error("tmr_quad: channel count does not fit the address map");
   end
   if (NARROW_W < 8 || NARROW_W >= CNT_W) begin : g_bad_width
      $error("tmr_quad: need 8 <= NARROW_W < CNT_W");
   end

   logic [WIN_W-1:0] win;
   logic [1:0]       slot;
   logic             shared_sel;

   assign win        = bus_addr[ADDR_W-1:4];
   assign slot       = bus_addr[3:2];
   assign shared_sel = (win == '0);

   logic [NCH-1:0]   evt, mask_v, raw_v, mis_v;
   logic [CNT_W-1:0] cnt_v  [NCH];
   logic [CNT_W-1:0] load_v [NCH];
   logic [CNT_W-1:0] bg_v   [NCH];
   logic [7:0]       ctl_v  [NCH];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = (win == WIN_W'(i + 1));
      tmr_chan #(
         .CNT_W(CNT_W), .NARROW_W(NARROW_W),
         .DIV_MID(DIV_MID), .DIV_MAX(DIV_MAX)
      ) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_we   (bus_we && sel && slot == SLOT_LOAD),
         .ctl_we  (bus_we && sel && slot == SLOT_CTL),
         .bg_we   (bus_we && sel && slot == SLOT_BG),
         .wdata   (bus_wdata),
         .count_o (cnt_v[i]),
         .load_o  (load_v[i]),
         .bg_o    (bg_v[i]),
         .ctl_o   (ctl_v[i]),
         .zero_evt(evt[i])
      );
   end

   tmr_irq #(.NCH(NCH)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_we(bus_we && shared_sel && slot == SH_MASK),
      .clr_we (bus_we && shared_sel && slot == SH_CLR),
      .wbits  (bus_wdata[NCH-1:0]),
      .evt    (evt),
      .mask_o (mask_v),
      .raw_o  (raw_v),
      .mis_o  (mis_v),
      .irq_o  (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (shared_sel) begin
         case (slot)
            SH_MASK: bus_rdata = CNT_W'(mask_v);
            SH_RAW:  bus_rdata = CNT_W'(raw_v);
            SH_MIS:  bus_rdata = CNT_W'(mis_v);
            default: bus_rdata = '0;
         endcase
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (win == WIN_W'(i + 1)) begin
               case (slot)
                  SLOT_LOAD: bus_rdata = load_v[i];
                  SLOT_CNT:  bus_rdata = cnt_v[i];
                  SLOT_CTL:  bus_rdata = CNT_W'(ctl_v[i]);
                  default:   bus_rdata = bg_v[i];
               endcase
            end
         end
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq_o && raw_v == '0));
endmodule

// File: tb/sim_tmr_quad.sv
module sim_tmr_quad;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr_quad u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [7:0] a_ch(input int ch, input int slot);
      return 8'(16 + 16 * ch + 4 * slot);
   endfunction

   function automatic int div_of(input int code);
      return (code == 0) ? 1 : (code == 1) ? 16 : 256;
   endfunction

   function automatic logic [31:0] exp_after(input logic [31:0] l, input int m, input int code);
      return l - 32'(m / div_of(code));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input int ch, input logic [7:0] ctl, input logic [31:0] l);
      wr(a_ch(ch, 2), 32'h0);
      wr(a_ch(ch, 0), l);
      wr(8'h0C, 32'(1 << ch));
      wr(a_ch(ch, 2), {24'h0, ctl});
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      waitn(3);
      rst_n = 1'b1;
      waitn(1);

      // R1 reset state
      for (int ch = 0; ch < 4; ch++) begin
         rd(a_ch(ch, 1), v); check("R1 count", v, 0);
         rd(a_ch(ch, 2), v); check("R1 ctl", v, 0);
      end
      rd(8'h04, v); check("R1 raw", v, 0);
      check("R1 irq", {31'h0, irq_o}, 0);

      // R2 R8 load word, 16-bit cut
      wr(a_ch(0, 0), 32'h0001_2345);
      rd(a_ch(0, 1), v); check("R8 narrow load", v, 32'h2345);
      rd(a_ch(0, 0), v); check("R2 load readback", v, 32'h0001_2345);
      rd(a_ch(0, 3), v); check("R2 staged copy", v, 32'h0001_2345);
      waitn(5);
      rd(a_ch(0, 1), v); check("R3 disabled hold", v, 32'h2345);

      // R11 control readback and unmapped reads
      wr(a_ch(3, 2), 32'hFFFF_FFFF);
      rd(a_ch(3, 2), v); check("R11 ctl bits", v, 32'hCF);
      wr(a_ch(3, 2), 32'h0);
      rd(8'h0C, v); check("R11 clear reads zero", v, 0);
      rd(8'h60, v); check("R11 unmapped", v, 0);

      // R3 random tick spacing over all prescale codes
      for (int i = 0; i < 24; i++) begin
         int ch, code, m;
         logic [31:0] l;
         ch = int'($urandom % 4);
         code = int'($urandom % 4);
         l = 32'(50 + $urandom % 400);
         m = (code == 0) ? int'($urandom % 40) : int'($urandom % 700);
         setup(ch, 8'(8'hC2 | (code << 2)), l);
         waitn(m);
         rd(a_ch(ch, 1), v); check("R3 tick spacing", v, exp_after(l, m, code));
         rd(a_ch(ch, 2), v); check("R11 ctl random", v, 32'(8'hC2 | (code << 2)));
      end

      // R4 R5 staged value in periodic mode
      setup(1, 8'hC0, 32'd5);
      waitn(1);
      wr(a_ch(1, 3), 32'd9);
      rd(a_ch(1, 1), v); check("R4 staged write keeps count", v, 32'd3);
      waitn(4);
      rd(a_ch(1, 1), v); check("R5 periodic reload from staged", v, 32'd9);

      // R6 R8 free-running wrap
      setup(3, 8'h80, 32'd3);
      waitn(4);
      rd(a_ch(3, 1), v); check("R6 wrap 16-bit", v, 32'hFFFF);
      waitn(1);
      rd(a_ch(3, 1), v); check("R6 after wrap", v, 32'hFFFE);
      setup(0, 8'h82, 32'd2);
      waitn(3);
      rd(a_ch(0, 1), v); check("R8 wrap 32-bit", v, 32'hFFFF_FFFF);

      // quiet all channels, clear flags
      for (int ch = 0; ch < 4; ch++) wr(a_ch(ch, 2), 32'h0);
      wr(8'h0C, 32'hF);
      rd(8'h04, v); check("R9 clear all", v, 0);

      // R7 R9 R10 one-shot and interrupt path
      setup(2, 8'hC1, 32'd3);
      waitn(10);
      rd(a_ch(2, 1), v); check("R7 one-shot holds zero", v, 0);
      rd(8'h04, v); check("R9 raw set", v, 32'h4);
      rd(8'h08, v); check("R10 masked off", v, 0);
      check("R10 irq masked off", {31'h0, irq_o}, 0);
      wr(8'h00, 32'h4);
      rd(8'h08, v); check("R10 masked on", v, 32'h4);
      check("R10 irq on", {31'h0, irq_o}, 1);
      wr(8'h0C, 32'h4);
      rd(8'h04, v); check("R9 cleared", v, 0);
      check("R10 irq off", {31'h0, irq_o}, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule